// File: doc/BRIEF.md
# GPIO Port with Interrupt-on-Change

An eight-pin general-purpose I/O port. A host reaches it through a small register file on a simple synchronous bus made of an address, a write strobe, a read strobe, write data and registered read data. Each pin is set on its own as an input or as an output. An output pin drives the value held in its latch. An input is synchronized and can be read back inverted.

The block can raise an interrupt when a pin changes. Each enabled pin is checked in one of two ways. It can be compared with the pin's own value one cycle earlier, or with a programmed reference bit. The first hit latches a flag for every pin that matched and takes a snapshot of the port. The interrupt line stays high, and flags and snapshot stay frozen, until the host reads the capture register or the port register.

Top module: `gpio_ioc_port`

## Requirements
- R1: After reset, all direction bits are 1 (all pins inputs, `pin_oe_o` = 0). Every other writable register, the flags and the capture are 0. `irq_o` is low and `rdata_o` is 0.
- R2: Address 0 holds the direction bits. A bit of 1 makes the pin an input, and a bit of 0 makes it an output. `pin_oe_o` is the inverse of the direction bits and `pin_o` equals the output latch. Both update in the cycle after the write.
- R3: A read of address 9 returns the doubly synchronized pin levels XOR the polarity bits (address 1). A level applied to `pin_i` first shows up in a read issued two cycles later.
- R4: A write to address 9 or to address 10 loads the output latch. A read of address 10 returns the latch, not the pin levels.
- R5: With interrupt-control bit 0 (address 4), an enabled pin hits when its synchronized level differs from its level one cycle earlier.
- R6: With interrupt-control bit 1, an enabled pin hits when its synchronized level (before polarity) differs from its reference bit (address 3).
- R7: Only pins whose enable bit (address 2) is 1 can hit. When no interrupt is pending and any pin hits, the flag register (address 7) loads the set of hitting pins on the next edge.
- R8: On the edge that loads the flags, the capture register (address 8) loads the port value as read at address 9. While any flag is set, flags and capture do not change except by a clearing read. The capture keeps its value after the clear.
- R9: A read of address 8 or address 9 clears all flags on that edge. A clear wins over a hit in the same cycle.
- R10: Writes to addresses 7 and 8 are ignored. Reads of addresses 11 to 15 return 0, and writes to them have no effect. Addresses 5 and 6 are plain 8-bit storage.
- R11: `irq_o` is high exactly while at least one flag bit is set.
- R12: `rdata_o` is registered. It shows the addressed register in the cycle after `rd_en_i` and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pin_i | input | 8 | Pad input levels (asynchronous) |
| pin_o | output | 8 | Output latch value driven to pads |
| pin_oe_o | output | 8 | Per-pin output enable |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The assertions assume that the host never asserts the write strobe and the read strobe in the same cycle. They also assume that every bus input is stable across each clock edge. The stimulus drives all inputs only on the falling edge, and each bus task raises exactly one strobe. Pin levels also change only on the falling edge, so the two-flop synchronizer gives a fixed, countable latency that the bench model reproduces.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR  = 4'd0,
    A_POL  = 4'd1,
    A_IEN  = 4'd2,
    A_REF  = 4'd3,
    A_ICTL = 4'd4,
    A_CFG  = 4'd5,
    A_PUP  = 4'd6,
    A_FLAG = 4'd7,
    A_CAP  = 4'd8,
    A_PORT = 4'd9,
    A_LAT  = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/gpio_ioc_sync.sv
module gpio_ioc_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_ioc_regs.sv
module gpio_ioc_regs
  import gpio_ioc_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  port_val_i,
  input  logic [WIDTH-1:0]  flag_i,
  input  logic [WIDTH-1:0]  cap_i,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  pol_o,
  output logic [WIDTH-1:0]  ien_o,
  output logic [WIDTH-1:0]  ref_o,
  output logic [WIDTH-1:0]  ictl_o,
  output logic [WIDTH-1:0]  lat_o,
  output logic              clr_o,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] cfg_q, pup_q, rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '1;
      pol_o  <= '0;
      ien_o  <= '0;
      ref_o  <= '0;
      ictl_o <= '0;
      cfg_q  <= '0;
      pup_q  <= '0;
      lat_o  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_DIR:          dir_o  <= wdata_i;
        A_POL:          pol_o  <= wdata_i;
        A_IEN:          ien_o  <= wdata_i;
        A_REF:          ref_o  <= wdata_i;
        A_ICTL:         ictl_o <= wdata_i;
        A_CFG:          cfg_q  <= wdata_i;
        A_PUP:          pup_q  <= wdata_i;
        A_PORT, A_LAT:  lat_o  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_DIR:   rd_mux = dir_o;
      A_POL:   rd_mux = pol_o;
      A_IEN:   rd_mux = ien_o;
      A_REF:   rd_mux = ref_o;
      A_ICTL:  rd_mux = ictl_o;
      A_CFG:   rd_mux = cfg_q;
      A_PUP:   rd_mux = pup_q;
      A_FLAG:  rd_mux = flag_i;
      A_CAP:   rd_mux = cap_i;
      A_PORT:  rd_mux = port_val_i;
      A_LAT:   rd_mux = lat_o;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign clr_o = rd_en_i && (addr_i == A_CAP || addr_i == A_PORT);
endmodule

// File: rtl/gpio_ioc_detect.sv
module gpio_ioc_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_s_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] ien_i,
  input  logic [WIDTH-1:0] ref_i,
  input  logic [WIDTH-1:0] ictl_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] hit_o,
  output logic [WIDTH-1:0] flag_o,
  output logic [WIDTH-1:0] cap_o
);
  logic [WIDTH-1:0] prev_q;
  logic             pend;

  // per-pin comparison source picked by the control bit
  for (genvar g = 0; g < WIDTH; g++) begin : g_cmp
    assign hit_o[g] = ien_i[g] &
                      (ictl_i[g] ? (pin_s_i[g] ^ ref_i[g]) : (pin_s_i[g] ^ prev_q[g]));
  end

  assign pend = |flag_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_o <= '0;
      cap_o  <= '0;
    end else begin
      prev_q <= pin_s_i;
      if (clr_i) begin
        flag_o <= '0;
      end else if (!pend && |hit_o) begin
        flag_o <= hit_o;
        cap_o  <= pin_s_i ^ pol_i;
      end
    end
  end
endmodule

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port
  import gpio_ioc_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] pin_s, dir_q, pol_q, ien_q, ref_q, ictl_q, lat_q;
  logic [WIDTH-1:0] flag_q, cap_q, hit_w;
  logic             clr_w;

  gpio_ioc_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  gpio_ioc_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .wdata_i   (wdata_i),
    .port_val_i(pin_s ^ pol_q),
    .flag_i    (flag_q),
    .cap_i     (cap_q),
    .dir_o     (dir_q),
    .pol_o     (pol_q),
    .ien_o     (ien_q),
    .ref_o     (ref_q),
    .ictl_o    (ictl_q),
    .lat_o     (lat_q),
    .clr_o     (clr_w),
    .rdata_o   (rdata_o)
  );

  gpio_ioc_detect #(.WIDTH(WIDTH)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_s_i(pin_s),
    .pol_i  (pol_q),
    .ien_i  (ien_q),
    .ref_i  (ref_q),
    .ictl_i (ictl_q),
    .clr_i  (clr_w),
    .hit_o  (hit_w),
    .flag_o (flag_q),
    .cap_o  (cap_q)
  );

  assign pin_o    = lat_q;
  assign pin_oe_o = ~dir_q;
  assign irq_o    = |flag_q;
endmodule

// File: rtl/gpio_ioc_checker.sv
module gpio_ioc_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       addr_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic [WIDTH-1:0] pin_o,
  input logic [WIDTH-1:0] pin_oe_o,
  input logic             irq_o,
  input logic [WIDTH-1:0] flag_q,
  input logic [WIDTH-1:0] cap_q,
  input logic [WIDTH-1:0] hit_w
);
  logic clr_rd;
  assign clr_rd = rd_en_i && (addr_i == 4'd8 || addr_i == 4'd9);

  assert_dir_oe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd0) |=> (pin_oe_o == ~$past(wdata_i)));

  assert_lat_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == 4'd9 || addr_i == 4'd10)) |=> (pin_o == $past(wdata_i)));

  assert_first_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !clr_rd && hit_w != '0) |=> (flag_q == $past(hit_w)));

  assert_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_rd) |=> ($stable(flag_q) && $stable(cap_q)));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_rd |=> !irq_o);

  assert_irq_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(hit_w) != '0));

  assert_no_strobe_clash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && rd_en_i));
endmodule

bind gpio_ioc_port gpio_ioc_checker #(.WIDTH(WIDTH)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .wdata_i (wdata_i),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o),
  .flag_q  (flag_q),
  .cap_q   (cap_q),
  .hit_w   (hit_w)
);

// File: tb/gpio_ioc_port_tb.sv
module gpio_ioc_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, pin_in = '0;
  logic [7:0] rdata, pin_out, pin_oe;
  logic       irq;

  int tests = 0, fails = 0;
  string phase = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ioc_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // behavioural reference model
  logic [7:0] m_dir = 8'hFF, m_pol = 0, m_ien = 0, m_ref = 0, m_ictl = 0, m_cfg = 0, m_pup = 0;
  logic [7:0] m_lat = 0, m_flag = 0, m_cap = 0, m_rd = 0;
  logic [7:0] m_s1 = 0, m_s2 = 0, m_prev = 0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_dir = 8'hFF; m_pol = 0; m_ien = 0; m_ref = 0; m_ictl = 0; m_cfg = 0; m_pup = 0;
      m_lat = 0; m_flag = 0; m_cap = 0; m_rd = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      logic [7:0] hit, port_v, nxt_rd;
      port_v = m_s2 ^ m_pol;
      hit = 0;
      for (int b = 0; b < 8; b++)
        if (m_ien[b]) hit[b] = m_ictl[b] ? (m_s2[b] != m_ref[b]) : (m_s2[b] != m_prev[b]);
      case (addr)
        0: nxt_rd = m_dir;   1: nxt_rd = m_pol;  2: nxt_rd = m_ien;  3: nxt_rd = m_ref;
        4: nxt_rd = m_ictl;  5: nxt_rd = m_cfg;  6: nxt_rd = m_pup;  7: nxt_rd = m_flag;
        8: nxt_rd = m_cap;   9: nxt_rd = port_v; 10: nxt_rd = m_lat;
        default: nxt_rd = 0;
      endcase
      if (rd_en) m_rd = nxt_rd;
      if (rd_en && (addr == 8 || addr == 9)) m_flag = 0;
      else if (m_flag == 0 && hit != 0) begin m_flag = hit; m_cap = port_v; end
      if (wr_en)
        case (addr)
          0: m_dir = wdata;  1: m_pol = wdata;  2: m_ien = wdata;  3: m_ref = wdata;
          4: m_ictl = wdata; 5: m_cfg = wdata;  6: m_pup = wdata;
          9, 10: m_lat = wdata;
          default: ;
        endcase
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("rdata", rdata, m_rd);
    chk("pin_o", pin_out, m_lat);
    chk("pin_oe", pin_oe, ~m_dir);
    chk("irq", {7'd0, irq}, {7'd0, m_flag != 0});
  endtask

  task automatic cyc(input logic w, input logic r, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    compare();
    wr_en = w; rd_en = r; addr = a; wdata = d;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d); cyc(1, 0, a, d); endtask
  task automatic rd(input logic [3:0] a); cyc(0, 1, a, 8'h00); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(0, 0, 4'd0, 8'h00); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    chk("reset irq", {7'd0, irq}, 8'd0);
    chk("reset oe", pin_oe, 8'h00);
    chk("reset rdata", rdata, 8'h00);
    rst_ni = 1'b1;
    rd(0); rd(2); rd(8); idle(1);

    phase = "R2";
    wr(0, 8'h0F); wr(10, 8'hA5); idle(2); rd(0);
    phase = "R4";
    wr(9, 8'h3C); rd(10); pin_in = 8'hFF; idle(3); rd(10); idle(1);

    phase = "R3";
    pin_in = 8'h96; rd(9); rd(9); rd(9); wr(1, 8'h0F); rd(9); rd(1); idle(1);

    phase = "R10";
    wr(7, 8'hFF); wr(8, 8'hFF); rd(7); rd(8); wr(12, 8'h55); rd(12); rd(15);
    wr(5, 8'h12); wr(6, 8'h34); rd(5); rd(6); idle(1);

    phase = "R7";
    wr(1, 8'h00); wr(2, 8'h01); wr(4, 8'h00); idle(3);
    pin_in = 8'h16; idle(4); rd(7);
    phase = "R5";
    pin_in = 8'h17; idle(4); rd(7);
    phase = "R8";
    pin_in = 8'h16; idle(4); rd(7); rd(8); idle(1);
    phase = "R9";
    rd(9); idle(1); rd(7); rd(8); idle(3);

    phase = "R6";
    wr(2, 8'h02); wr(3, 8'h00); wr(4, 8'h02); idle(2); rd(7); rd(8);
    phase = "R9";
    rd(8); idle(2); rd(7);
    wr(3, 8'h02); rd(9); idle(2); rd(7);

    phase = "R12";
    rd(10); idle(3); wr(10, 8'h00); idle(2);

    phase = "R11";
    for (int i = 0; i < 1500; i++) begin
      int unsigned k = $urandom_range(0, 9);
      if (k < 3) pin_in = 8'($urandom);
      if (k == 4)      wr(4'($urandom_range(0, 10)), 8'($urandom));
      else if (k >= 5) rd(4'($urandom_range(0, 15)));
      else             idle(1);
    end
    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule